// File: doc/BRIEF.md
# Immediate Formatter with Upper-Byte Merge

This block turns the low 11 bits of an instruction word into a 16-bit immediate operand. Two selects shape the value. One chooses between passing the field through as-is, for arithmetic operands, and moving it up by one bit, for jump and branch offsets that count in halfwords. The other chooses between filling the upper bits with zeros and copying the field's sign bit into them. The formatted value can be offered to any mix of three consumers: operand bus A, operand bus B and the program counter load path. Each consumer has its own enable, and the block reports whether it drives that consumer through an output-valid flag that stands in for a tri-state driver.

A second path serves the load-upper-immediate operation. It keeps the low byte of the operand bus A value, puts the low eight instruction bits in the upper byte, and offers the result to the data bus under its own enable. This path does not depend on the immediate selects or the destination enables.

All outputs are registered, so each output reflects the inputs sampled at the previous rising clock edge. A synchronous active-low reset clears every value and every valid flag.

Top module: `imm_fmt_unit`

## Requirements
- R1: While reset is asserted at a rising edge, every output value and every valid flag is 0 after that edge.
- R2: With shift select 0 and extend select 0, the immediate is the 11-bit field in bits 10..0, with bits 15..11 zero.
- R3: With shift select 0 and extend select 1, the immediate is the field in bits 10..0 with field bit 10 copied into bits 15..11.
- R4: With shift select 1 and extend select 0, the immediate is the field in bits 11..1, bit 0 zero and bits 15..12 zero.
- R5: With shift select 1 and extend select 1, the immediate is the field in bits 11..1, bit 0 zero, and field bit 10 copied into bits 15..12.
- R6: Destination enable bit 0 is operand bus A, bit 1 is operand bus B, bit 2 is the program counter load path; each enabled destination has valid flag 1 and carries the immediate, each disabled one has valid flag 0 and value 0, independently of the others.
- R7: With the merge enable at 1, the data bus value is the low 8 instruction bits in bits 15..8 and bus A bits 7..0 in bits 7..0, with its valid flag 1; with the merge enable at 0 the value and flag are 0.
- R8: The merge output does not depend on the shift select, the extend select or the destination enables, and the immediate outputs do not depend on the merge enable or on bus A.
- R9: Every output reflects the inputs sampled at the previous rising clock edge (one cycle of latency).
- R10: Instruction bits 15..11 have no effect on any immediate output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| instr_word | input | 16 | Current instruction word |
| shift_sel | input | 1 | 1: move field up by one bit |
| sext_sel | input | 1 | 1: sign-extend, 0: zero-extend |
| dst_en | input | 3 | Destination enables: bit0 bus A, bit1 bus B, bit2 PC load |
| lui_en | input | 1 | Enable for the upper-byte merge onto the data bus |
| a_bus_in | input | 16 | Current operand bus A value |
| a_imm_val | output | 16 | Immediate offered to bus A |
| a_imm_oe | output | 1 | Bus A immediate valid |
| b_imm_val | output | 16 | Immediate offered to bus B |
| b_imm_oe | output | 1 | Bus B immediate valid |
| pc_imm_val | output | 16 | Immediate offered to the PC load path |
| pc_imm_oe | output | 1 | PC load immediate valid |
| d_lui_val | output | 16 | Merged value offered to the data bus |
| d_lui_oe | output | 1 | Data bus merged value valid |

## Verification
On every cycle the assertions check that a destination's valid flag follows its enable from the previous edge, that a disabled destination carries zero, that the upper bits of each mode's result hold zeros or copies of field bit 10 as the mode demands, that a shifted result has bit 0 clear, and that the merged data bus value pairs the earlier instruction byte with the earlier bus A byte. Only the bench's scenarios show the full value equality in each of the four modes against an independent arithmetic model, the independence of the merge path from the immediate selects, the lack of effect of instruction bits 15..11, and the interplay of several destinations enabled together across mode changes.

// File: rtl/imm_fmt_pkg.sv
package imm_fmt_pkg;
    localparam int NUM_DST = 3;

    typedef enum logic [1:0] {
        DST_A  = 2'd0,
        DST_B  = 2'd1,
        DST_PC = 2'd2
    } dst_idx_e;
endpackage

// File: rtl/imm_shift_ext.sv
module imm_shift_ext #(
    parameter int FIELD_W = 11,
    parameter int DATA_W  = 16
) (
    input  logic [FIELD_W-1:0] field_i,
    input  logic               shift_i,
    input  logic               sext_i,
    output logic [DATA_W-1:0]  imm_o
);
    logic fill_bit;

    always_comb begin
        fill_bit = sext_i & field_i[FIELD_W-1];
        imm_o    = {DATA_W{fill_bit}};
        if (shift_i) begin
            imm_o[FIELD_W:0] = {field_i, 1'b0};
        end else begin
            imm_o[FIELD_W-1:0] = field_i;
        end
    end
endmodule

// File: rtl/imm_lane_gate.sv
module imm_lane_gate #(
    parameter int DATA_W = 16
) (
    input  logic              en_i,
    input  logic [DATA_W-1:0] val_i,
    output logic [DATA_W-1:0] val_o,
    output logic              oe_o
);
    always_comb begin
        oe_o  = en_i;
        val_o = en_i ? val_i : '0;
    end
endmodule

// File: rtl/lui_byte_merge.sv
module lui_byte_merge #(
    parameter int DATA_W = 16,
    parameter int BYTE_W = 8
) (
    input  logic [BYTE_W-1:0] instr_lo_i,
    input  logic [DATA_W-1:0] a_bus_i,
    output logic [DATA_W-1:0] merged_o
);
    localparam int KEEP_W = DATA_W - BYTE_W;

    always_comb begin
        merged_o = {instr_lo_i, a_bus_i[KEEP_W-1:0]};
    end
endmodule

// File: rtl/imm_fmt_unit.sv
module imm_fmt_unit
    import imm_fmt_pkg::*;
#(
    parameter int DATA_W  = 16,
    parameter int FIELD_W = 11,
    parameter int BYTE_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] instr_word,
    input  logic              shift_sel,
    input  logic              sext_sel,
    input  logic [2:0]        dst_en,
    input  logic              lui_en,
    input  logic [DATA_W-1:0] a_bus_in,
    output logic [DATA_W-1:0] a_imm_val,
    output logic              a_imm_oe,
    output logic [DATA_W-1:0] b_imm_val,
    output logic              b_imm_oe,
    output logic [DATA_W-1:0] pc_imm_val,
    output logic              pc_imm_oe,
    output logic [DATA_W-1:0] d_lui_val,
    output logic              d_lui_oe
);
    localparam int HI_W  = DATA_W - FIELD_W;
    localparam int HIS_W = DATA_W - FIELD_W - 1;

    typedef struct packed {
        logic [NUM_DST-1:0][DATA_W-1:0] imm_val;
        logic [NUM_DST-1:0]             imm_oe;
        logic [DATA_W-1:0]              lui_val;
        logic                           lui_oe;
    } out_state_t;

    out_state_t state_d, state_q;

    logic [DATA_W-1:0]              imm_fmt;
    logic [DATA_W-1:0]              lui_merged;
    logic [NUM_DST-1:0][DATA_W-1:0] lane_val;
    logic [NUM_DST-1:0]             lane_oe;

    imm_shift_ext #(.FIELD_W(FIELD_W), .DATA_W(DATA_W)) u_shift_ext (
        .field_i (instr_word[FIELD_W-1:0]),
        .shift_i (shift_sel),
        .sext_i  (sext_sel),
        .imm_o   (imm_fmt)
    );

    for (genvar g = 0; g < NUM_DST; g++) begin : g_lane
        imm_lane_gate #(.DATA_W(DATA_W)) u_gate (
            .en_i  (dst_en[g]),
            .val_i (imm_fmt),
            .val_o (lane_val[g]),
            .oe_o  (lane_oe[g])
        );

        // R6: a lane without valid never carries a value
        a_r6_off_lane_zero: assert property (@(posedge clk) disable iff (!rst_n)
            !state_q.imm_oe[g] |-> state_q.imm_val[g] == '0);

        // R9: valid flag follows the enable seen one edge earlier
        a_r9_oe_follows_en: assert property (@(posedge clk) disable iff (!rst_n)
            1'b1 |=> state_q.imm_oe[g] == $past(dst_en[g]));
    end

    lui_byte_merge #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_lui (
        .instr_lo_i (instr_word[BYTE_W-1:0]),
        .a_bus_i    (a_bus_in),
        .merged_o   (lui_merged)
    );

    always_comb begin
        state_d.imm_val = lane_val;
        state_d.imm_oe  = lane_oe;
        state_d.lui_oe  = lui_en;
        state_d.lui_val = lui_en ? lui_merged : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign a_imm_val  = state_q.imm_val[DST_A];
    assign a_imm_oe   = state_q.imm_oe[DST_A];
    assign b_imm_val  = state_q.imm_val[DST_B];
    assign b_imm_oe   = state_q.imm_oe[DST_B];
    assign pc_imm_val = state_q.imm_val[DST_PC];
    assign pc_imm_oe  = state_q.imm_oe[DST_PC];
    assign d_lui_val  = state_q.lui_val;
    assign d_lui_oe   = state_q.lui_oe;

    a_r2_zext_upper_clear: assert property (@(posedge clk) disable iff (!rst_n)
        dst_en[0] && !shift_sel && !sext_sel |=> a_imm_val[DATA_W-1:FIELD_W] == '0);

    a_r3_sext_upper_copy: assert property (@(posedge clk) disable iff (!rst_n)
        dst_en[1] && !shift_sel && sext_sel
        |=> b_imm_val[DATA_W-1:FIELD_W] == {HI_W{$past(instr_word[FIELD_W-1])}});

    a_r4_shift_low_clear: assert property (@(posedge clk) disable iff (!rst_n)
        dst_en[2] && shift_sel |=> pc_imm_val[0] == 1'b0);

    a_r5_shift_sext_upper: assert property (@(posedge clk) disable iff (!rst_n)
        dst_en[2] && shift_sel && sext_sel
        |=> pc_imm_val[DATA_W-1:FIELD_W+1] == {HIS_W{$past(instr_word[FIELD_W-1])}});

    a_r7_lui_merge: assert property (@(posedge clk) disable iff (!rst_n)
        lui_en |=> d_lui_oe
                   && d_lui_val[DATA_W-1:DATA_W-BYTE_W] == $past(instr_word[BYTE_W-1:0])
                   && d_lui_val[DATA_W-BYTE_W-1:0] == $past(a_bus_in[DATA_W-BYTE_W-1:0]));

    a_r7_lui_off: assert property (@(posedge clk) disable iff (!rst_n)
        !lui_en |=> !d_lui_oe && d_lui_val == '0);
endmodule

// File: tb/imm_fmt_unit_tb.sv
module imm_fmt_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [15:0] instr_word;
    logic        shift_sel, sext_sel, lui_en;
    logic [2:0]  dst_en;
    logic [15:0] a_bus_in;
    logic [15:0] a_imm_val, b_imm_val, pc_imm_val, d_lui_val;
    logic        a_imm_oe, b_imm_oe, pc_imm_oe, d_lui_oe;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    // expected outputs after the next rising edge
    logic [15:0] e_a, e_b, e_pc, e_d;
    logic        e_aoe, e_boe, e_pcoe, e_doe;

    always #4 clk = ~clk;

    imm_fmt_unit dut_i (
        .clk(clk), .rst_n(rst_n), .instr_word(instr_word),
        .shift_sel(shift_sel), .sext_sel(sext_sel), .dst_en(dst_en),
        .lui_en(lui_en), .a_bus_in(a_bus_in),
        .a_imm_val(a_imm_val), .a_imm_oe(a_imm_oe),
        .b_imm_val(b_imm_val), .b_imm_oe(b_imm_oe),
        .pc_imm_val(pc_imm_val), .pc_imm_oe(pc_imm_oe),
        .d_lui_val(d_lui_val), .d_lui_oe(d_lui_oe)
    );

    function automatic logic [15:0] ref_imm(input logic [15:0] w, input bit sh, input bit sx);
        int f, v, width;
        f     = int'(w) % 2048;
        v     = sh ? f * 2 : f;
        width = sh ? 12 : 11;
        if (sx && v >= (1 << (width - 1))) v = v - (1 << width) + 65536;
        return 16'(v);
    endfunction

    function automatic string mode_tag(input bit sh, input bit sx);
        if (!sh && !sx) return "R2";
        if (!sh &&  sx) return "R3";
        if ( sh && !sx) return "R4";
        return "R5";
    endfunction

    task automatic cmp(input string req, input string what, input logic [16:0] act, input logic [16:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    string cur_tag = "R1";

    task automatic check_all();
        cmp(cur_tag, "busA", {a_imm_oe, a_imm_val}, {e_aoe, e_a});
        cmp({cur_tag, "/R6"}, "busB", {b_imm_oe, b_imm_val}, {e_boe, e_b});
        cmp({cur_tag, "/R9"}, "pc", {pc_imm_oe, pc_imm_val}, {e_pcoe, e_pc});
        cmp({cur_tag, "/R7"}, "data", {d_lui_oe, d_lui_val}, {e_doe, e_d});
    endtask

    // check outputs of the previous edge, then apply new inputs and predict
    task automatic step(input string tag, input logic rn, input logic [15:0] w, input bit sh,
                        input bit sx, input logic [2:0] en, input bit le, input logic [15:0] a);
        logic [15:0] imm;
        @(negedge clk);
        check_all();
        rst_n = rn; instr_word = w; shift_sel = sh; sext_sel = sx;
        dst_en = en; lui_en = le; a_bus_in = a;
        cur_tag = tag;
        imm = ref_imm(w, sh, sx);
        if (!rn) begin
            {e_a, e_b, e_pc, e_d} = '0;
            {e_aoe, e_boe, e_pcoe, e_doe} = '0;
        end else begin
            e_aoe = en[0]; e_a = en[0] ? imm : 16'h0;
            e_boe = en[1]; e_b = en[1] ? imm : 16'h0;
            e_pcoe = en[2]; e_pc = en[2] ? imm : 16'h0;
            e_doe = le; e_d = le ? {w[7:0], a[7:0]} : 16'h0;
        end
    endtask

    initial begin
        rst_n = 0; instr_word = 16'hFFFF; shift_sel = 1; sext_sel = 1;
        dst_en = 3'b111; lui_en = 1; a_bus_in = 16'hFFFF;
        {e_a, e_b, e_pc, e_d} = '0;
        {e_aoe, e_boe, e_pcoe, e_doe} = '0;
        @(posedge clk); @(posedge clk);
        // R1: reset with all inputs active
        step("R1", 0, 16'hFFFF, 1, 1, 3'b111, 1, 16'hFFFF);
        // four modes with the sign bit set and clear
        step("R2", 1, 16'h0400, 0, 0, 3'b111, 0, 16'h0000);
        step("R3", 1, 16'h0400, 0, 1, 3'b111, 0, 16'h0000);
        step("R3", 1, 16'h03FF, 0, 1, 3'b111, 0, 16'h0000);
        step("R4", 1, 16'h07FF, 1, 0, 3'b111, 0, 16'h0000);
        step("R5", 1, 16'h07FF, 1, 1, 3'b111, 0, 16'h0000);
        step("R5", 1, 16'h03FF, 1, 1, 3'b111, 0, 16'h0000);
        step("R5", 1, 16'h0400, 1, 1, 3'b111, 0, 16'h0000);
        // R10: upper instruction bits must not leak
        step("R10", 1, 16'hF801, 0, 0, 3'b111, 0, 16'h0000);
        step("R10", 1, 16'hF801, 1, 0, 3'b111, 0, 16'h0000);
        // R6: destinations individually
        step("R6", 1, 16'h0555, 0, 0, 3'b001, 0, 16'h0000);
        step("R6", 1, 16'h0555, 0, 0, 3'b010, 0, 16'h0000);
        step("R6", 1, 16'h0555, 1, 1, 3'b100, 0, 16'h0000);
        step("R6", 1, 16'h0555, 1, 1, 3'b000, 0, 16'h0000);
        // R7/R8: merge path, independent of immediate controls
        step("R7", 1, 16'h12A5, 0, 0, 3'b000, 1, 16'hBEEF);
        step("R8", 1, 16'h12A5, 1, 1, 3'b111, 1, 16'hBEEF);
        step("R8", 1, 16'h12A5, 1, 1, 3'b111, 0, 16'hBEEF);
        step("R8", 1, 16'h12A5, 0, 1, 3'b101, 1, 16'h1234);
        // R9: back-to-back changes every cycle
        for (int i = 0; i < 300; i++) begin
            logic [15:0] w, a;
            bit sh, sx, le;
            logic [2:0] en;
            w = 16'($urandom); a = 16'($urandom);
            sh = bit'($urandom % 2); sx = bit'($urandom % 2); le = bit'($urandom % 2);
            en = 3'($urandom);
            step(i == 0 ? "R9" : mode_tag(sh, sx), 1, w, sh, sx, en, le, a);
        end
        // R1: reset in mid-run
        step("R1", 0, 16'h7FFF, 1, 1, 3'b111, 1, 16'hFFFF);
        step("R2", 1, 16'h0001, 0, 0, 3'b011, 1, 16'h00FF);
        @(negedge clk);
        check_all();
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule